// File: doc/BRIEF.md
# Second-level cache maintenance sequencer

This block holds the maintenance control registers of a second-level cache and runs the whole-cache and address-range maintenance jobs that software requests through them. Software programs a control word, then either writes one of two whole-cache command registers or writes a range end followed by a range start. The start write launches the job. A sequencer then steps through cache lines on a simple tag-array port. It clears valid bits, and for dirty lines it raises write-back requests that carry the line address. It holds a busy flag until the last line has been handled.

The cache is direct-mapped, with `NUM_SETS` sets and lines of `LINE_BYTES` bytes (64 or 128). A line address is the byte address with the line offset removed. Its low `log2(NUM_SETS)` bits index the tag array and the rest form the tag.

Three kinds of job exist. A flush writes back dirty lines and leaves them valid and clean. An invalidate clears lines without any write-back. A flush-then-invalidate writes back dirty lines and then clears them.

The write-back port is valid/ready. `wb_valid` and `wb_addr` stay asserted and stable until `wb_ready` is seen high at a clock edge. While the request waits, the sequencer holds its position, so back-pressure only stretches the job.

The tag-array read is combinational on `tag_idx`. A tag write takes effect at the clock edge and goes to the same index.

Top module: `l2_maint_seq`

## Requirements
- R1: After reset the control word reads 0, `cache_disable`, `wb_valid` and `tag_we` are low, and no job runs.
- R2: Register word offsets are fixed: control 0, whole invalidate 1, whole flush 2, range end 3, range start 4. In the control word:
  - bit 0 is the disable bit and drives `cache_disable`;
  - bit 6 is the invalidate-mode bit;
  - bit 8 is the read-only busy flag;
  - bit 9 is the range-op bit;
  - all other bits read 0.
- R3: Writing 1 in bit 0 of the whole-invalidate register while the invalidate-mode bit is 0 clears every valid line. It issues no write-back.
- R4: Writing 1 in bit 0 of the whole-invalidate register while the invalidate-mode bit is 1 first writes back every valid dirty line, then clears it.
- R5: Writing 1 in bit 0 of the whole-flush register writes back every valid dirty line and leaves it valid and clean. It ignores the invalidate-mode bit.
- R6: A write to the range start register launches a range job over every line address from start through the stored end, inclusive. Address bits below the line size are ignored. Only lines whose set is valid with a matching tag are affected. A range-op bit of 0 means flush. A range-op bit of 1 means invalidate when the invalidate-mode bit is 0, and flush-then-invalidate when it is 1.
- R7: The busy flag reads 1 in the cycle after the launching write. It stays 1 until every affected line is done. Each line that needs no write-back takes exactly one cycle.
- R8: A write-back request is raised only for a valid dirty line. `wb_valid` and `wb_addr` (tag, set index, zero offset) stay stable until `wb_ready`. Requests leave in ascending line order.
- R9: While busy, every register write is ignored except the disable bit of the control word. Ignored writes include commands, the end and start registers, and the invalidate-mode and range-op bits.
- R10: A range start write with a start address above the stored end address launches nothing. Busy stays 0 and no line is touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write word offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read word offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| cache_disable | output | 1 | Disable bit of the control word |
| tag_idx | output | 4 | Set index for tag read and write |
| tag_rd_valid | input | 1 | Valid bit of the indexed set |
| tag_rd_dirty | input | 1 | Dirty bit of the indexed set |
| tag_rd_tag | input | 22 | Tag of the indexed set |
| tag_we | output | 1 | Tag-array write enable |
| tag_wr_valid | output | 1 | Valid bit to write |
| tag_wr_dirty | output | 1 | Dirty bit to write |
| wb_valid | output | 1 | Write-back request valid |
| wb_addr | output | 32 | Byte address of the line to write back |
| wb_ready | input | 1 | Write-back request accepted |

## Verification
Two things can fall in the same cycle: a write-back acknowledge that advances the sequencer, and a software register write that arrives while the job is still busy. The bench provokes this by running a whole-cache flush with a pseudo-random `wb_ready`. During that flush it writes the control word (disable, invalidate-mode and range-op all set), the range end register and the whole-invalidate command. A behavioural model of the tag array and a queue of expected write-back addresses judge the result. Every handshake must match the queue head. The final array must equal a flush-only outcome, the control word must show only the disable change, and the end register must read back its earlier value.

// File: rtl/l2m_pkg.sv
package l2m_pkg;
  typedef enum logic [1:0] {
    K_FLUSH = 2'd0,
    K_INV   = 2'd1,
    K_FINV  = 2'd2
  } maint_kind_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_INV   = 3'd1;
  localparam logic [2:0] RA_FLUSH = 3'd2;
  localparam logic [2:0] RA_END   = 3'd3;
  localparam logic [2:0] RA_START = 3'd4;

  localparam int CB_DIS  = 0;
  localparam int CB_IM   = 6;
  localparam int CB_BUSY = 8;
  localparam int CB_RGN  = 9;
endpackage

// File: rtl/l2m_range.sv
module l2m_range #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  localparam int LA_W  = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [LA_W-1:0]   first_line,
  output logic [LA_W-1:0]   last_line,
  output logic              empty
);
  // Offset bits drop out of the line numbers; the emptiness test uses
  // the full byte addresses.
  assign first_line = start_addr[ADDR_W-1:OFF_W];
  assign last_line  = end_addr[ADDR_W-1:OFF_W];
  assign empty      = end_addr < start_addr;
endmodule

// File: rtl/l2m_regs.sv
module l2m_regs
  import l2m_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 6,
  parameter int NUM_SETS = 16,
  localparam int LA_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              busy,
  output logic              cache_disable,
  output logic              launch,
  output logic              launch_entire,
  output maint_kind_e       launch_kind,
  output logic [LA_W-1:0]   launch_first,
  output logic [LA_W-1:0]   launch_last
);
  logic              dis_q, im_q, rgn_q;
  logic [ADDR_W-1:0] end_q, start_q;
  logic              wr_ok;
  logic [LA_W-1:0]   r_first, r_last;
  logic              r_empty;
  logic              go_inv, go_flush, go_rgn;

  assign wr_ok = reg_we && !busy;

  l2m_range #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_range (
    .start_addr (reg_wdata),
    .end_addr   (end_q),
    .first_line (r_first),
    .last_line  (r_last),
    .empty      (r_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      im_q    <= 1'b0;
      rgn_q   <= 1'b0;
      end_q   <= '0;
      start_q <= '0;
    end else if (reg_we) begin
      if (reg_waddr == RA_CTRL) begin
        dis_q <= reg_wdata[CB_DIS];
        if (!busy) begin
          im_q  <= reg_wdata[CB_IM];
          rgn_q <= reg_wdata[CB_RGN];
        end
      end
      if (!busy && reg_waddr == RA_END)   end_q   <= reg_wdata;
      if (!busy && reg_waddr == RA_START) start_q <= reg_wdata;
    end
  end

  assign go_inv   = wr_ok && reg_waddr == RA_INV   && reg_wdata[0];
  assign go_flush = wr_ok && reg_waddr == RA_FLUSH && reg_wdata[0];
  assign go_rgn   = wr_ok && reg_waddr == RA_START && !r_empty;

  assign launch        = go_inv || go_flush || go_rgn;
  assign launch_entire = !go_rgn;

  always_comb begin
    if (go_inv)       launch_kind = im_q ? K_FINV : K_INV;
    else if (go_rgn)  launch_kind = rgn_q ? (im_q ? K_FINV : K_INV) : K_FLUSH;
    else              launch_kind = K_FLUSH;
  end

  assign launch_first = go_rgn ? r_first : '0;
  assign launch_last  = go_rgn ? r_last  : LA_W'(NUM_SETS - 1);

  assign cache_disable = dis_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      RA_CTRL: begin
        reg_rdata[CB_DIS]  = dis_q;
        reg_rdata[CB_IM]   = im_q;
        reg_rdata[CB_BUSY] = busy;
        reg_rdata[CB_RGN]  = rgn_q;
      end
      RA_END:   reg_rdata = end_q;
      RA_START: reg_rdata = start_q;
      default:  reg_rdata = '0;
    endcase
  end

  a_r9_end_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_waddr == RA_END) |=> $stable(end_q));

  a_r2_dis_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == RA_CTRL) |=> (cache_disable == $past(reg_wdata[CB_DIS])));
endmodule

// File: rtl/l2m_walker.sv
module l2m_walker
  import l2m_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 6,
  parameter int NUM_SETS = 16,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int LA_W    = ADDR_W - OFF_W,
  localparam int TAG_W   = LA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_entire,
  input  maint_kind_e       launch_kind,
  input  logic [LA_W-1:0]   launch_first,
  input  logic [LA_W-1:0]   launch_last,
  output logic              busy,
  output logic [IDX_W-1:0]  tag_idx,
  input  logic              tag_rd_valid,
  input  logic              tag_rd_dirty,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  output logic              tag_we,
  output logic              tag_wr_valid,
  output logic              tag_wr_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready
);
  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_WB} wstate_e;

  wstate_e          state;
  logic [LA_W-1:0]  cur, last_q;
  logic             entire_q;
  maint_kind_e      kind_q;
  logic [TAG_W-1:0] wtag_q;
  logic             hit, need_wb, drop, line_done;

  assign hit     = tag_rd_valid && (entire_q || tag_rd_tag == cur[LA_W-1:IDX_W]);
  assign need_wb = hit && tag_rd_dirty && kind_q != K_INV;
  assign drop    = hit && !need_wb && kind_q != K_FLUSH;

  assign line_done = (state == S_PROBE && !need_wb) || (state == S_WB && wb_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      last_q   <= '0;
      entire_q <= 1'b0;
      kind_q   <= K_FLUSH;
      wtag_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          state    <= S_PROBE;
          cur      <= launch_first;
          last_q   <= launch_last;
          entire_q <= launch_entire;
          kind_q   <= launch_kind;
        end
        S_PROBE: if (need_wb) begin
          state  <= S_WB;
          wtag_q <= tag_rd_tag;
        end
        default: ;
      endcase
      if (line_done) begin
        if (cur == last_q) state <= S_IDLE;
        else begin
          state <= S_PROBE;
          cur   <= cur + 1'b1;
        end
      end
    end
  end

  assign busy         = state != S_IDLE;
  assign tag_idx      = cur[IDX_W-1:0];
  assign tag_we       = (state == S_PROBE && drop) || (state == S_WB && wb_ready);
  assign tag_wr_valid = kind_q == K_FLUSH;
  assign tag_wr_dirty = 1'b0;
  assign wb_valid     = state == S_WB;
  assign wb_addr      = {wtag_q, cur[IDX_W-1:0], {OFF_W{1'b0}}};

  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  a_r8_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (tag_rd_valid && tag_rd_dirty && tag_rd_tag == wtag_q));

  a_r3_inv_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q == K_INV) |-> !wb_valid);
endmodule

// File: rtl/l2_maint_seq.sv
module l2_maint_seq
  import l2m_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int NUM_SETS   = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int TAG_W     = LA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              cache_disable,
  output logic [IDX_W-1:0]  tag_idx,
  input  logic              tag_rd_valid,
  input  logic              tag_rd_dirty,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  output logic              tag_we,
  output logic              tag_wr_valid,
  output logic              tag_wr_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ready
);
  logic            busy, launch, launch_entire;
  maint_kind_e     launch_kind;
  logic [LA_W-1:0] launch_first, launch_last;

  l2m_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_SETS(NUM_SETS)) u_regs (
    .clk, .rst_n, .reg_we, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
    .busy, .cache_disable, .launch, .launch_entire, .launch_kind,
    .launch_first, .launch_last
  );

  l2m_walker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_SETS(NUM_SETS)) u_walk (
    .clk, .rst_n, .launch, .launch_entire, .launch_kind, .launch_first,
    .launch_last, .busy, .tag_idx, .tag_rd_valid, .tag_rd_dirty, .tag_rd_tag,
    .tag_we, .tag_wr_valid, .tag_wr_dirty, .wb_valid, .wb_addr, .wb_ready
  );

  a_r7_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  a_r9_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

// File: tb/sim_l2_maint_seq.sv
`timescale 1ns/1ps
module sim_l2_maint_seq;
  localparam int NS = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cache_disable, tag_we, tag_wr_valid, tag_wr_dirty, wb_valid;
  logic [3:0] tag_idx;
  logic [31:0] wb_addr;
  logic wb_ready = 1'b0;
  logic tag_rd_valid, tag_rd_dirty;
  logic [21:0] tag_rd_tag;

  logic bv[NS], bd[NS];
  logic [21:0] bt[NS];
  logic ev[NS], ed[NS];
  logic [21:0] et[NS];
  logic ld_en = 1'b0, ld_v = 1'b0, ld_d = 1'b0;
  logic [3:0] ld_i = '0;
  logic [21:0] ld_t = '0;
  logic [31:0] exp_q[$];
  logic op_active = 1'b0, stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  int checks = 0, fails = 0, mchecks = 0, mfails = 0;
  logic prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  l2_maint_seq u0 (
    .clk, .rst_n, .reg_we, .reg_waddr, .reg_wdata, .reg_raddr, .reg_rdata,
    .cache_disable, .tag_idx, .tag_rd_valid, .tag_rd_dirty, .tag_rd_tag,
    .tag_we, .tag_wr_valid, .tag_wr_dirty, .wb_valid, .wb_addr, .wb_ready
  );

  assign tag_rd_valid = bv[tag_idx];
  assign tag_rd_dirty = bd[tag_idx];
  assign tag_rd_tag   = bt[tag_idx];

  // Behavioural tag array, also loaded by the bench between jobs.
  always @(posedge clk) begin
    if (ld_en) begin
      bv[ld_i] <= ld_v; bd[ld_i] <= ld_d; bt[ld_i] <= ld_t;
    end else if (tag_we) begin
      bv[tag_idx] <= tag_wr_valid; bd[tag_idx] <= tag_wr_dirty;
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wb_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // Per-clock monitor of the write-back port and tag writes (R8, R10).
  always @(negedge clk) if (rst_n) begin
    if (tag_we && !op_active) begin
      mchecks++; mfails++;
      $display("FAIL R10: tag write outside a job, actual 1 expected 0");
    end
    if (prev_wait) begin
      mchecks++;
      if (!wb_valid || wb_addr != prev_addr) begin
        mfails++;
        $display("FAIL R8: request dropped or changed, actual %0h expected %0h", wb_addr, prev_addr);
      end
    end
    if (wb_valid && wb_ready) begin
      mchecks++;
      if (exp_q.size() == 0) begin
        mfails++;
        $display("FAIL R8: unexpected write-back, actual %0h expected none", wb_addr);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (wb_addr != e) begin
          mfails++;
          $display("FAIL R8: write-back address, actual %0h expected %0h", wb_addr, e);
        end
      end
    end
    prev_wait = wb_valid && !wb_ready;
    prev_addr = wb_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a; #1; d = reg_rdata; reg_raddr = 3'd0;
  endtask

  task automatic load(input int pat);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_i = 4'(i);
      if (pat == 0) begin
        ld_v = (i % 4) != 3; ld_d = (i % 2) == 0; ld_t = 22'h100 + 22'(i);
      end else begin
        ld_v = i != 7; ld_d = (i % 3) != 1; ld_t = (i == 4) ? 22'h101 : 22'h100;
      end
      ev[i] = ld_v; ed[i] = ld_d; et[i] = ld_t;
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  // kind: 0 flush, 1 invalidate, 2 flush-then-invalidate
  task automatic model(input bit ent, input int kind, input int first, input int last);
    for (int la = first; la <= last; la++) begin
      int idx;
      idx = la % NS;
      if (ev[idx] && (ent || et[idx] == 22'(la / NS))) begin
        if (ed[idx] && kind != 1) exp_q.push_back({et[idx], 4'(idx), 6'b0});
        if (kind != 0) ev[idx] = 1'b0;
        ed[idx] = 1'b0;
      end
    end
  endtask

  task automatic wait_idle(input string req, output int cyc);
    cyc = 0;
    while (reg_rdata[8] && cyc < 5000) begin cyc++; @(negedge clk); end
    op_active = 1'b0;
    chk(cyc < 5000, req, 32'(cyc), 0);
  endtask

  task automatic compare(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < NS; i++)
      if (bv[i] !== ev[i] || bd[i] !== ed[i]) bad++;
    chk(bad == 0, req, 32'(bad), 0);
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 0);
  endtask

  task automatic launch(input logic [2:0] a, input logic [31:0] d, input string req);
    op_active = 1'b1;
    wr(a, d);
    chk(reg_rdata[8] === 1'b1, req, 32'(reg_rdata[8]), 1);  // busy next cycle
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + mchecks - fails - mfails, checks + mchecks + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, d); chk(d == 0, "R1", d, 0);
    chk(!cache_disable && !wb_valid && !tag_we, "R1", {cache_disable, wb_valid, tag_we}, 0);
    // R2 control layout
    wr(3'd0, 32'h241); rd(3'd0, d); chk(d == 32'h241, "R2", d, 32'h241);
    chk(cache_disable, "R2", 32'(cache_disable), 1);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk(d == 32'h241, "R2", d, 32'h241);
    wr(3'd0, 32'h0);
    // R3 whole invalidate, mode 0, plus R7 cycle count
    load(0); model(1'b1, 1, 0, NS - 1);
    launch(3'd1, 32'h1, "R7");
    wait_idle("R7", cyc); chk(cyc == NS, "R7", 32'(cyc), NS);
    compare("R3");
    // R4 whole invalidate, mode 1
    load(0); wr(3'd0, 32'h40); stall_en = 1'b1; model(1'b1, 2, 0, NS - 1);
    launch(3'd1, 32'h1, "R7"); wait_idle("R4", cyc); compare("R4");
    // R5 whole flush ignores mode bit
    load(0); model(1'b1, 0, 0, NS - 1);
    launch(3'd2, 32'h1, "R7"); wait_idle("R5", cyc); compare("R5");
    // R6 range flush, offsets ignored, tag mismatch at set 4
    load(1); wr(3'd0, 32'h0); wr(3'd3, 32'h0004_0000 + 32'd8 * 64 + 32'h3F);
    model(1'b0, 0, 32'h1002, 32'h1008);
    launch(3'd4, 32'h0004_0000 + 32'd2 * 64 + 32'h05, "R7"); wait_idle("R6", cyc); compare("R6");
    rd(3'd4, d); chk(d == 32'h0004_0085, "R6", d, 32'h0004_0085);
    // R6 range invalidate (range-op 1, mode 0)
    load(1); wr(3'd0, 32'h200); model(1'b0, 1, 32'h1002, 32'h1008);
    launch(3'd4, 32'h0004_0080, "R7"); wait_idle("R6", cyc); compare("R6");
    // R6 range flush-then-invalidate (range-op 1, mode 1)
    load(1); wr(3'd0, 32'h240); model(1'b0, 2, 32'h1002, 32'h1008);
    launch(3'd4, 32'h0004_0080, "R7"); wait_idle("R6", cyc); compare("R6");
    // R9 writes during busy, collide with acknowledges
    load(0); wr(3'd0, 32'h0); wr(3'd3, 32'h0000_1234); model(1'b1, 0, 0, NS - 1);
    launch(3'd2, 32'h1, "R7");
    wr(3'd0, 32'h241); wr(3'd3, 32'h0000_DEAD); wr(3'd1, 32'h1);
    chk(cache_disable, "R9", 32'(cache_disable), 1);
    wait_idle("R9", cyc); compare("R9");
    rd(3'd0, d); chk(d == 32'h1, "R9", d, 32'h1);
    rd(3'd3, d); chk(d == 32'h1234, "R9", d, 32'h1234);
    // R10 start above end launches nothing
    load(0); stall_en = 1'b0;
    wr(3'd3, 32'h100); wr(3'd4, 32'h200);
    chk(reg_rdata[8] == 1'b0, "R10", 32'(reg_rdata[8]), 0);
    repeat (4) @(negedge clk);
    compare("R10");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks + mchecks - fails - mfails, checks + mchecks);
    $finish;
  end
endmodule